// File: doc/BRIEF.md
# DMA Channel Register File

This block stores the programmable state of a four-channel DMA engine. Each channel has a 16-bit memory address and a 16-bit transfer word. The transfer word holds a 14-bit remaining count and a 2-bit transfer kind. The block also holds one mode byte and the latched terminal-count flags.

A host loads and reads these registers one byte at a time over an 8-bit port. A first/last pointer flip-flop decides whether each access reaches the low half or the high half of a 16-bit register. A transfer sequencer uses the other side of the block. It picks a channel with `act_ch` and sees that channel's address, count and kind. It pulses `upd_stb` after each transfer to step the registers. The block reports when the upper address byte has to be re-latched, and it turns channels off or reloads them at terminal count, as the mode byte selects.

Top module: `dma_chan_regs`

## Requirements
- R1: While `rst` is high, every address, count, kind, mode bit and terminal-count flag is cleared and the byte pointer returns to low. `ch_en` therefore reads 0.
- R2: `reg_addr` values 0 to 7 select a channel register. Bits 2:1 give the channel, and bit 0 picks the address (0) or the transfer word (1). Value 8 writes the mode byte and reads the status byte. Values 9 to 15 read as 0 and ignore writes.
- R3: One access happens in each clock cycle that has `cs` high and a strobe low. A channel-register access reaches the low byte while the pointer is clear and the high byte while it is set, then toggles the pointer. A mode write clears the pointer. Status reads and accesses to unused addresses leave the pointer unchanged.
- R4: In the transfer word, bits 13:0 hold the byte count minus one and bits 15:14 hold the kind: 00 verify, 01 write, 10 read. For the channel named by `act_ch`, `cur_cnt` and `cur_kind` show these fields and `cur_addr` shows the address.
- R5: An `upd_stb` cycle adds one to the address of channel `act_ch` and subtracts one from its count, with wrap-around in both. The kind is kept. `cur_last` is high while the selected count is zero.
- R6: `carry_hi` is high for exactly the one cycle after an update that carried out of the low address byte (old low byte 0xFF), or after an update that reloaded the channel.
- R7: An update while the count is zero is a terminal count and sets status bit `act_ch`. A status read returns the four flags in bits 3:0 and zeros above, then clears them. A terminal count in the same cycle as the read stays set.
- R8: Mode byte bits 3:0 enable channels 0 to 3. Bit 4 drives `rot_pri`, bit 5 drives `ext_wr`, bit 6 drives `stop_on_tc` and bit 7 drives `auto_ld`.
- R9: When `stop_on_tc` is set, a terminal count clears the enable bit of that channel.
- R10: When `auto_ld` is set, `ch_en` shows at most channel 2. At a channel-2 terminal count, channel 2 takes its address and transfer word from channel 3 instead of stepping.
- R11: When both strobes are low with `cs` high, the cycle counts as a write only. It has no read side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Host register select |
| cs | input | 1 | Host select |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte |
| upd_stb | input | 1 | One transfer finished on channel `act_ch` |
| act_ch | input | 2 | Channel seen and updated by the sequencer |
| cur_addr | output | 16 | Address of the selected channel |
| cur_cnt | output | 14 | Remaining count of the selected channel |
| cur_kind | output | 2 | Transfer kind of the selected channel |
| cur_last | output | 1 | Selected count is zero |
| carry_hi | output | 1 | Upper address byte must be re-latched |
| ch_en | output | 4 | Effective channel enables |
| rot_pri | output | 1 | Rotating priority selected |
| ext_wr | output | 1 | Extended write selected |
| stop_on_tc | output | 1 | Disable channel at terminal count |
| auto_ld | output | 1 | Channel 2 reload mode |

## Verification
Byte-serial loads and read-backs are run on several channels. Some of them interleave mode writes, so a pointer that fails to clear or to toggle shows up as swapped bytes. Updates are run in four settings: an address mid-range, an address whose low byte rolls over from 0xFF, a count that runs through zero with neither stop nor reload, and a count that reaches terminal count with stop or with auto-load. These separate plain stepping from carry reporting, from disabling and from reloading. Collision cases cover a status read in the same cycle as a terminal count, and both strobes low together. They show whether set beats clear and whether write beats read.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 14;
    localparam int KIND_W = 2;
    localparam int WORD_W = CNT_W + KIND_W;

    localparam logic [3:0] MODE_SLOT  = 4'h8;
    localparam int         RELOAD_DST = 2;
    localparam int         RELOAD_SRC = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [KIND_W-1:0] kind;
        logic [CNT_W-1:0]  cnt;
    } chan_regs_t;

    typedef struct packed {
        logic           auto_ld;
        logic           stop_tc;
        logic           ext_wr;
        logic           rot_pri;
        logic [NCH-1:0] en;
    } mode_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CHAN,
        TGT_MODE
    } tgt_e;

    function automatic tgt_e decode_tgt(input logic [3:0] a);
        if (!a[3])
            return TGT_CHAN;
        else if (a == MODE_SLOT)
            return TGT_MODE;
        else
            return TGT_NONE;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/dma_flptr.sv
module dma_flptr (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic clear,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            hi <= 1'b0;
        else if (step)
            hi <= ~hi;
    end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_word,
    input  logic       wr_hi,
    input  logic [7:0] wr_byte,
    input  logic       upd,
    input  logic       reload_en,
    input  chan_regs_t reload_val,
    output chan_regs_t regs,
    output logic       tc_hit,
    output logic       carry
);
    logic       at_zero;
    logic       do_reload;
    chan_regs_t nxt;
    logic [WORD_W-1:0] word_tmp;

    assign at_zero   = (regs.cnt == '0);
    assign do_reload = upd && reload_en && at_zero;
    assign tc_hit    = upd && at_zero;
    assign carry     = upd && (do_reload || (&regs.addr[7:0]));

    always_comb begin
        nxt      = regs;
        word_tmp = '0;
        if (do_reload) begin
            nxt = reload_val;
        end else if (upd) begin
            nxt.addr = regs.addr + 1'b1;
            nxt.cnt  = regs.cnt - 1'b1;
        end
        if (wr_en) begin
            if (!wr_word) begin
                if (wr_hi) nxt.addr[15:8] = wr_byte;
                else       nxt.addr[7:0]  = wr_byte;
            end else begin
                word_tmp = {nxt.kind, nxt.cnt};
                if (wr_hi) word_tmp[15:8] = wr_byte;
                else       word_tmp[7:0]  = wr_byte;
                {nxt.kind, nxt.cnt} = word_tmp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            regs <= '0;
        else
            regs <= nxt;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          reg_addr,
    input  logic                cs,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    input  logic                upd_stb,
    input  logic [CH_W-1:0]     act_ch,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [CNT_W-1:0]    cur_cnt,
    output logic [KIND_W-1:0]   cur_kind,
    output logic                cur_last,
    output logic                carry_hi,
    output logic [NCH-1:0]      ch_en,
    output logic                rot_pri,
    output logic                ext_wr,
    output logic                stop_on_tc,
    output logic                auto_ld
);
    logic            wr_acc;
    logic            rd_acc;
    tgt_e            tgt;
    logic [CH_W-1:0] sel_ch;
    logic            sel_word;
    logic            fl_hi;
    logic            rd_status;
    mode_t           mode_q;
    logic [NCH-1:0]  tc_flags;
    logic [NCH-1:0]  tc_v;
    logic [NCH-1:0]  carry_v;
    chan_regs_t      regs [NCH];
    chan_regs_t      cur;

    // Write has priority over read when both strobes are low
    assign wr_acc    = cs && !wr_n;
    assign rd_acc    = cs && !rd_n && wr_n;
    assign tgt       = decode_tgt(reg_addr);
    assign sel_ch    = reg_addr[CH_W:1];
    assign sel_word  = reg_addr[0];
    assign rd_status = rd_acc && (tgt == TGT_MODE);

    dma_flptr u_ptr (
        .clk  (clk),
        .rst  (rst),
        .step ((wr_acc || rd_acc) && (tgt == TGT_CHAN)),
        .clear(wr_acc && (tgt == TGT_MODE)),
        .hi   (fl_hi)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_chan_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_acc && (tgt == TGT_CHAN) && (sel_ch == CH_W'(i))),
            .wr_word   (sel_word),
            .wr_hi     (fl_hi),
            .wr_byte   (wr_data),
            .upd       (upd_stb && (act_ch == CH_W'(i))),
            .reload_en ((i == RELOAD_DST) && mode_q.auto_ld),
            .reload_val(regs[RELOAD_SRC]),
            .regs      (regs[i]),
            .tc_hit    (tc_v[i]),
            .carry     (carry_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_acc && (tgt == TGT_MODE)) begin
            mode_q <= mode_t'(wr_data);
        end else if (mode_q.stop_tc) begin
            mode_q.en <= mode_q.en & ~tc_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tc_flags <= '0;
        else
            tc_flags <= (rd_status ? '0 : tc_flags) | tc_v;
    end

    always_ff @(posedge clk) begin
        if (rst)
            carry_hi <= 1'b0;
        else
            carry_hi <= |carry_v;
    end

    always_comb begin
        rd_data = '0;
        case (tgt)
            TGT_CHAN: begin
                if (sel_word)
                    rd_data = pick_byte({regs[sel_ch].kind, regs[sel_ch].cnt}, fl_hi);
                else
                    rd_data = pick_byte(regs[sel_ch].addr, fl_hi);
            end
            TGT_MODE: rd_data = {{(8-NCH){1'b0}}, tc_flags};
            default:  rd_data = '0;
        endcase
    end

    assign cur        = regs[act_ch];
    assign cur_addr   = cur.addr;
    assign cur_cnt    = cur.cnt;
    assign cur_kind   = cur.kind;
    assign cur_last   = (cur.cnt == '0);
    assign ch_en      = mode_q.en & (mode_q.auto_ld ? NCH'(1 << RELOAD_DST) : {NCH{1'b1}});
    assign rot_pri    = mode_q.rot_pri;
    assign ext_wr     = mode_q.ext_wr;
    assign stop_on_tc = mode_q.stop_tc;
    assign auto_ld    = mode_q.auto_ld;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  reg_addr,
    input logic        cs,
    input logic        rd_n,
    input logic        wr_n,
    input logic        upd_stb,
    input logic [1:0]  act_ch,
    input logic [15:0] cur_addr,
    input logic        cur_last,
    input logic        carry_hi,
    input logic [3:0]  ch_en,
    input logic        stop_on_tc,
    input logic        auto_ld,
    input logic        fl_hi,
    input logic [3:0]  tc_flags
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (ch_en == 4'h0 && tc_flags == 4'h0 && !fl_hi));

    assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (cs && !wr_n && !reg_addr[3]) |=> (fl_hi != $past(fl_hi)));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cs && !wr_n && reg_addr == 4'h8) |=> !fl_hi);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && !cur_last && !(cs && !wr_n))
        |=> ((act_ch != $past(act_ch)) || (cur_addr == $past(cur_addr) + 16'd1)));

    assert_tc_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && cur_last) |=> tc_flags[$past(act_ch)]);

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (cs && !rd_n && wr_n && reg_addr == 4'h8 && !upd_stb) |=> (tc_flags == 4'h0));

    assert_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && cur_last && stop_on_tc && !(cs && !wr_n)) |=> !ch_en[$past(act_ch)]);

    assert_reload_carry_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && cur_last && auto_ld && act_ch == 2'd2) |=> carry_hi);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .cs        (cs),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .upd_stb   (upd_stb),
    .act_ch    (act_ch),
    .cur_addr  (cur_addr),
    .cur_last  (cur_last),
    .carry_hi  (carry_hi),
    .ch_en     (ch_en),
    .stop_on_tc(stop_on_tc),
    .auto_ld   (auto_ld),
    .fl_hi     (fl_hi),
    .tc_flags  (tc_flags)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = 4'h0;
    logic        cs = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        upd_stb = 1'b0;
    logic [1:0]  act_ch = 2'd0;
    logic [15:0] cur_addr;
    logic [13:0] cur_cnt;
    logic [1:0]  cur_kind;
    logic        cur_last;
    logic        carry_hi;
    logic [3:0]  ch_en;
    logic        rot_pri, ext_wr, stop_on_tc, auto_ld;

    dma_chan_regs uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .cs(cs), .rd_n(rd_n), .wr_n(wr_n),
        .wr_data(wr_data), .rd_data(rd_data), .upd_stb(upd_stb), .act_ch(act_ch),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .cur_kind(cur_kind), .cur_last(cur_last),
        .carry_hi(carry_hi), .ch_en(ch_en), .rot_pri(rot_pri), .ext_wr(ext_wr),
        .stop_on_tc(stop_on_tc), .auto_ld(auto_ld)
    );

    always #2 clk = ~clk;

    localparam int OB_RD = 0, OB_ADDR = 1, OB_CNT = 2, OB_KIND = 3,
                   OB_EN = 4, OB_CARRY = 5, OB_LAST = 6, OB_MODE = 7;

    typedef struct {
        int          sel;
        int unsigned exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    function automatic int unsigned observe(input int sel);
        case (sel)
            OB_RD:    return rd_data;
            OB_ADDR:  return cur_addr;
            OB_CNT:   return cur_cnt;
            OB_KIND:  return cur_kind;
            OB_EN:    return ch_en;
            OB_CARRY: return carry_hi;
            OB_LAST:  return cur_last;
            default:  return {auto_ld, stop_on_tc, ext_wr, rot_pri};
        endcase
    endfunction

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            int unsigned got;
            it  = sb_q.pop_front();
            got = observe(it.sel);
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, got, it.exp);
            end
        end
    end

    task automatic expect_now(input int sel, input int unsigned exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cs = 1'b1; wr_n = 1'b0; reg_addr = a; wr_data = d;
        @(posedge clk); #1;
        cs = 1'b0; wr_n = 1'b1;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        cs = 1'b1; rd_n = 1'b0; reg_addr = a;
        it.sel = OB_RD; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        cs = 1'b0; rd_n = 1'b1;
    endtask

    task automatic upd(input logic [1:0] ch);
        act_ch = ch; upd_stb = 1'b1;
        @(posedge clk); #1;
        upd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        expect_now(OB_EN, 4'h0, "R1 ch_en after reset");
        expect_now(OB_MODE, 4'h0, "R1 mode flags after reset");
        rd(4'h8, 8'h00, "R1 status after reset");
        rd(4'h0, 8'h00, "R1 ch0 addr low after reset");
        rd(4'h0, 8'h00, "R1 ch0 addr high after reset");

        // R2 R3 R4: byte-serial load and readback
        wr(4'h0, 8'h34); wr(4'h0, 8'h12);
        wr(4'h1, 8'h02); wr(4'h1, 8'h40);
        act_ch = 2'd0;
        expect_now(OB_ADDR, 16'h1234, "R3 ch0 address assembled");
        expect_now(OB_CNT, 14'd2, "R4 ch0 count field");
        expect_now(OB_KIND, 2'd1, "R4 ch0 kind write");
        rd(4'h0, 8'h34, "R2 ch0 addr low");
        rd(4'h0, 8'h12, "R2 ch0 addr high");
        rd(4'h1, 8'h02, "R2 ch0 word low");
        rd(4'h1, 8'h40, "R2 ch0 word high");

        // R3 R8: mode write clears pointer
        wr(4'h2, 8'hAA);
        wr(4'h8, 8'h0F);
        wr(4'h2, 8'hFE); wr(4'h2, 8'h00);
        expect_now(OB_EN, 4'hF, "R8 all enabled");
        expect_now(OB_MODE, 4'h0, "R8 no mode flags");
        act_ch = 2'd1;
        expect_now(OB_ADDR, 16'h00FE, "R3 pointer cleared by mode write");

        // R5 R7: stepping through terminal count
        upd(2'd0);
        expect_now(OB_ADDR, 16'h1235, "R5 addr step 1");
        expect_now(OB_CNT, 14'd1, "R5 count step 1");
        upd(2'd0);
        expect_now(OB_LAST, 1, "R5 last at zero");
        upd(2'd0);
        expect_now(OB_ADDR, 16'h1237, "R5 addr step 3");
        expect_now(OB_CNT, 14'h3FFF, "R5 count wraps");
        expect_now(OB_KIND, 2'd1, "R5 kind kept");
        rd(4'h8, 8'h01, "R7 status ch0 flag");
        rd(4'h8, 8'h00, "R7 status cleared by read");

        // R6: carry out of low address byte
        wr(4'h3, 8'h05); wr(4'h3, 8'h00);
        upd(2'd1);
        expect_now(OB_CARRY, 0, "R6 no carry at 0xFE");
        upd(2'd1);
        expect_now(OB_CARRY, 1, "R6 carry after 0xFF");
        expect_now(OB_CARRY, 0, "R6 carry lasts one cycle");
        act_ch = 2'd1;
        expect_now(OB_ADDR, 16'h0100, "R6 addr after carry");

        // R9: stop on terminal count
        wr(4'h8, 8'h4F);
        wr(4'h7, 8'h00); wr(4'h7, 8'h80);
        act_ch = 2'd3;
        expect_now(OB_KIND, 2'd2, "R4 ch3 kind read");
        expect_now(OB_LAST, 1, "R5 ch3 last");
        upd(2'd3);
        expect_now(OB_EN, 4'h7, "R9 ch3 disabled at tc");
        rd(4'h8, 8'h08, "R7 status ch3 flag");

        // R2: unused addresses
        wr(4'h9, 8'h55); wr(4'hC, 8'hFF);
        expect_now(OB_MODE, 4'h4, "R2 unused writes leave mode");
        expect_now(OB_EN, 4'h7, "R2 unused writes leave enables");
        rd(4'hA, 8'h00, "R2 unused address reads zero");
        rd(4'h1, 8'hFF, "R2 ch0 word low after unused access");

        // pointer now high after the single read above; re-align
        rd(4'h1, 8'h7F, "R3 ch0 word high");

        // R10: auto-load
        wr(4'h6, 8'h00); wr(4'h6, 8'h80);
        wr(4'h7, 8'h01); wr(4'h7, 8'h40);
        wr(4'h4, 8'h10); wr(4'h4, 8'h20);
        wr(4'h5, 8'h00); wr(4'h5, 8'h80);
        wr(4'h8, 8'h8F);
        expect_now(OB_EN, 4'h4, "R10 only ch2 enabled");
        expect_now(OB_MODE, 4'h8, "R8 auto flag");
        act_ch = 2'd2;
        expect_now(OB_ADDR, 16'h2010, "R10 ch2 start addr");
        upd(2'd2);
        expect_now(OB_CARRY, 1, "R10 reload flags carry");
        expect_now(OB_ADDR, 16'h8000, "R10 ch2 addr reloaded");
        expect_now(OB_CNT, 14'd1, "R10 ch2 count reloaded");
        expect_now(OB_KIND, 2'd1, "R10 ch2 kind reloaded");
        rd(4'h8, 8'h04, "R7 status ch2 flag");
        upd(2'd2);
        upd(2'd2);
        expect_now(OB_ADDR, 16'h8000, "R10 second reload");

        // R11: both strobes low counts as write
        cs = 1'b1; rd_n = 1'b0; wr_n = 1'b0; reg_addr = 4'h8; wr_data = 8'h3F;
        @(posedge clk); #1;
        cs = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        expect_now(OB_MODE, 4'h3, "R11 mode written");
        expect_now(OB_EN, 4'hF, "R11 enables written");
        rd(4'h8, 8'h04, "R11 status not cleared");

        // R7: terminal count coincides with status read
        wr(4'h1, 8'h00); wr(4'h1, 8'h00);
        act_ch = 2'd0;
        cs = 1'b1; rd_n = 1'b0; reg_addr = 4'h8; upd_stb = 1'b1;
        begin
            item_t it;
            it.sel = OB_RD; it.exp = 8'h00; it.tag = "R7 read before set";
            sb_q.push_back(it);
        end
        @(posedge clk); #1;
        cs = 1'b0; rd_n = 1'b1; upd_stb = 1'b0;
        rd(4'h8, 8'h01, "R7 set beats clear");

        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule